// File: doc/BRIEF.md
# Multi-Class Oldest-First Issue Selector

This block builds one issue bundle per request from the heads of five ready classes: integer, floating point, branch, memory and miscellaneous. Each class shows only its oldest ready entry: a valid bit, a sequence number and a squashed flag. The block pops that entry through a per-class pop strobe, and the next entry of the class is presented on the following clock. A smaller sequence number means an older instruction. Sequence numbers are compared as plain unsigned values.

A pulse on `start` while the block is idle begins an issue cycle. The state machine has three states. `ST_IDLE` waits for `start`. `ST_PICK` makes at most one pick per clock. `ST_DONE` presents the finished bundle for one clock. The transitions are:
- `ST_IDLE` to `ST_PICK` on `start`. This edge also clears the class quotas and the bundle.
- `ST_PICK` to itself while picks continue, including a cycle that only discards a squashed head.
- `ST_PICK` to `ST_DONE` when no class has an eligible head, or when a pick fills the last slot.
- `ST_DONE` to `ST_IDLE` unconditionally.

Each non-squashed pick is written to the next free slot. It also produces one pulse on `free_inc`, so the owner of the queues can return one entry.

Top module: `issue_oldest_select`

## Requirements
- R1: After reset, `busy`, `bundle_valid`, `free_inc`, `pop` and `slot_valid` are all zero.
- R2: A class head is eligible only when its valid bit is set and the class has issued fewer than its own limit in the current issue cycle. The default limits are integer 2, floating point 1, branch 1 and memory 2. Miscellaneous is bounded only by `ISSUE_W`. A pop is never raised for a class without a valid head.
- R3: Among eligible heads that are not squashed, the smallest sequence number is picked. On equal sequence numbers the lower class code wins. The class codes are integer 0, floating point 1, branch 2, memory 3 and miscellaneous 4.
- R4: If any eligible head is squashed, the squashed head with the lowest class code is popped in that pick. The pop uses no slot and no quota and gives no `free_inc`. A squashed head of a class already at its limit is not eligible and stays in place.
- R5: Picks fill slots from slot 0 upward in pick order. Each filled slot holds the sequence number and the 3-bit class code of its pick, and its valid bit is set. Unused slots are invalid.
- R6: Picking stops after `ISSUE_W` slots are filled or when no head is eligible. `bundle_valid` is then high for exactly one clock, and `issue_count` equals the number of filled slots, which may be zero.
- R7: `free_inc` pulses once for each issued instruction. `pop` has at most one bit set in any clock.
- R8: `start` has no effect while `busy` is high. Exactly one bundle is produced per accepted start.
- R9: Each accepted start clears the class quotas and the bundle. A class that reached its limit in one issue cycle is eligible again in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an issue cycle (accepted only when idle) |
| head_valid | input | 5 | Per-class head present |
| head_seq | input | 5*SEQ_W | Per-class head sequence number, class c at bits [c*SEQ_W +: SEQ_W] |
| head_squash | input | 5 | Per-class head is squashed |
| pop | output | 5 | Per-class pop strobe, head advances on the next clock |
| free_inc | output | 1 | One queue entry freed by an issue this clock |
| busy | output | 1 | Not in ST_IDLE |
| bundle_valid | output | 1 | Bundle complete (ST_DONE) |
| slot_valid | output | ISSUE_W | Slot filled |
| slot_seq | output | ISSUE_W*SEQ_W | Sequence number per slot |
| slot_cls | output | ISSUE_W*3 | Class code per slot |
| issue_count | output | clog2(ISSUE_W+1) | Number of filled slots |

## Verification
The assertions assume that a popped class replaces its head by the next clock edge. They also assume that the head inputs of a class change only after a pop of that class, or while the block is idle. The bench meets both assumptions with a per-class ring model. The model advances its read pointer on the edge after an observed pop, and new entries are loaded only between issue cycles. Because the rings keep leftover heads from earlier cases, later cases exercise ties and squashed entries against heads that were carried over.

// File: rtl/isel_pkg.sv
package isel_pkg;
    localparam int NUM_CLS = 5;
    localparam int CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_BR   = 3'd2,
        CLS_MEM  = 3'd3,
        CLS_MISC = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_DONE = 2'd2
    } sel_state_e;
endpackage

// File: rtl/isel_quota.sv
module isel_quota
    import isel_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int INT_LIM = 2,
    parameter int FP_LIM  = 1,
    parameter int BR_LIM  = 1,
    parameter int MEM_LIM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               take,
    input  logic [CLS_W-1:0]   take_cls,
    output logic [NUM_CLS-1:0] open
);
    localparam int CNT_W = $clog2(ISSUE_W + 1);

    function automatic int lim_of(input int c);
        int l;
        unique case (c)
            0:       l = INT_LIM;
            1:       l = FP_LIM;
            2:       l = BR_LIM;
            3:       l = MEM_LIM;
            default: l = ISSUE_W;
        endcase
        return (l > ISSUE_W) ? ISSUE_W : l;
    endfunction

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam int LIM = lim_of(c);
        logic [CNT_W-1:0] used_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                used_q <= '0;
            end else if (take && take_cls == CLS_W'(c)) begin
                used_q <= used_q + 1'b1;
            end
        end

        assign open[c] = (used_q < CNT_W'(LIM));

        // R2
        quota_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            used_q <= CNT_W'(LIM));
    end
endmodule

// File: rtl/isel_arbiter.sv
module isel_arbiter
    import isel_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic [NUM_CLS-1:0]       cand,
    input  logic [NUM_CLS*SEQ_W-1:0] seq,
    input  logic [NUM_CLS-1:0]       squash,
    output logic                     any_cand,
    output logic [CLS_W-1:0]         win_cls,
    output logic                     win_squash,
    output logic [SEQ_W-1:0]         win_seq
);
    logic             sq_found;
    logic [CLS_W-1:0] sq_cls;
    logic             old_found;
    logic [CLS_W-1:0] old_cls;
    logic [SEQ_W-1:0] old_seq;

    always_comb begin
        sq_found  = 1'b0;
        sq_cls    = '0;
        old_found = 1'b0;
        old_cls   = '0;
        old_seq   = '0;
        for (int i = 0; i < NUM_CLS; i++) begin
            if (cand[i] && squash[i] && !sq_found) begin
                sq_found = 1'b1;
                sq_cls   = CLS_W'(i);
            end
            if (cand[i] && (!old_found || seq[i*SEQ_W +: SEQ_W] < old_seq)) begin
                old_found = 1'b1;
                old_cls   = CLS_W'(i);
                old_seq   = seq[i*SEQ_W +: SEQ_W];
            end
        end
        any_cand   = old_found;
        win_squash = sq_found;
        win_cls    = sq_found ? sq_cls : old_cls;
        win_seq    = old_seq;
    end
endmodule

// File: rtl/isel_bundle.sv
module isel_bundle
    import isel_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int SEQ_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       put,
    input  logic [SEQ_W-1:0]           put_seq,
    input  logic [CLS_W-1:0]           put_cls,
    output logic [ISSUE_W-1:0]         slot_valid,
    output logic [ISSUE_W*SEQ_W-1:0]   slot_seq,
    output logic [ISSUE_W*CLS_W-1:0]   slot_cls,
    output logic [$clog2(ISSUE_W+1)-1:0] count
);
    localparam int CNT_W = $clog2(ISSUE_W + 1);
    localparam int IDX_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

    logic [SEQ_W-1:0] seq_q [ISSUE_W];
    logic [CLS_W-1:0] cls_q [ISSUE_W];
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = count[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            slot_valid <= '0;
            count      <= '0;
        end else if (put) begin
            slot_valid[wr_idx] <= 1'b1;
            count              <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (put) begin
            seq_q[wr_idx] <= put_seq;
            cls_q[wr_idx] <= put_cls;
        end
    end

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_out
        assign slot_seq[s*SEQ_W +: SEQ_W] = seq_q[s];
        assign slot_cls[s*CLS_W +: CLS_W] = cls_q[s];
    end

    // R6
    slot_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put |-> count < CNT_W'(ISSUE_W));
endmodule

// File: rtl/issue_oldest_select.sv
module issue_oldest_select
    import isel_pkg::*;
#(
    parameter int SEQ_W   = 8,
    parameter int ISSUE_W = 4,
    parameter int INT_LIM = 2,
    parameter int FP_LIM  = 1,
    parameter int BR_LIM  = 1,
    parameter int MEM_LIM = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [4:0]                   head_valid,
    input  logic [5*SEQ_W-1:0]           head_seq,
    input  logic [4:0]                   head_squash,
    output logic [4:0]                   pop,
    output logic                         free_inc,
    output logic                         busy,
    output logic                         bundle_valid,
    output logic [ISSUE_W-1:0]           slot_valid,
    output logic [ISSUE_W*SEQ_W-1:0]     slot_seq,
    output logic [ISSUE_W*3-1:0]         slot_cls,
    output logic [$clog2(ISSUE_W+1)-1:0] issue_count
);
    localparam int CNT_W = $clog2(ISSUE_W + 1);

    sel_state_e           state_q, state_d;
    logic                 accept;
    logic [NUM_CLS-1:0]   open, cand;
    logic                 any_cand, win_squash, take, last_put;
    logic [CLS_W-1:0]     win_cls;
    logic [SEQ_W-1:0]     win_seq;

    assign accept   = (state_q == ST_IDLE) && start;
    assign cand     = (state_q == ST_PICK) ? (head_valid & open) : '0;
    assign take     = any_cand && !win_squash;
    assign last_put = take && (issue_count == CNT_W'(ISSUE_W - 1));

    isel_quota #(
        .ISSUE_W(ISSUE_W), .INT_LIM(INT_LIM), .FP_LIM(FP_LIM),
        .BR_LIM(BR_LIM), .MEM_LIM(MEM_LIM)
    ) i_quota (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .take(take), .take_cls(win_cls), .open(open)
    );

    isel_arbiter #(.SEQ_W(SEQ_W)) i_arb (
        .cand(cand), .seq(head_seq), .squash(head_squash),
        .any_cand(any_cand), .win_cls(win_cls),
        .win_squash(win_squash), .win_seq(win_seq)
    );

    isel_bundle #(.ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W)) i_bundle (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .put(take), .put_seq(win_seq), .put_cls(win_cls),
        .slot_valid(slot_valid), .slot_seq(slot_seq),
        .slot_cls(slot_cls), .count(issue_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PICK;
            ST_PICK: if (!any_cand || last_put) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pop          = '0;
        if (any_cand) pop[win_cls] = 1'b1;
        free_inc     = take;
        busy         = (state_q != ST_IDLE);
        bundle_valid = (state_q == ST_DONE);
    end

    // R7
    pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
    // R7
    free_has_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_inc |-> (pop != '0));
    // R2
    pop_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop & ~head_valid) == '0);
    // R6
    bundle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |=> !bundle_valid);
    // R5
    slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |-> $countones(slot_valid) == int'(issue_count));
    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/test_issue_oldest_select.sv
module test_issue_oldest_select;
    localparam int SEQ_W = 8;
    localparam int IW    = 4;
    localparam int NC    = 5;
    localparam int CW    = $clog2(IW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NC-1:0] head_valid, head_squash, pop;
    logic [NC*SEQ_W-1:0] head_seq;
    logic free_inc, busy, bundle_valid;
    logic [IW-1:0] slot_valid;
    logic [IW*SEQ_W-1:0] slot_seq;
    logic [IW*3-1:0] slot_cls;
    logic [CW-1:0] issue_count;

    always #5 clk = ~clk;

    issue_oldest_select #(.SEQ_W(SEQ_W), .ISSUE_W(IW)) i_issue_oldest_select (
        .clk(clk), .rst_n(rst_n), .start(start),
        .head_valid(head_valid), .head_seq(head_seq), .head_squash(head_squash),
        .pop(pop), .free_inc(free_inc), .busy(busy), .bundle_valid(bundle_valid),
        .slot_valid(slot_valid), .slot_seq(slot_seq), .slot_cls(slot_cls),
        .issue_count(issue_count)
    );

    // Per-class ring model of the ready queues
    logic [SEQ_W-1:0] q_seq [NC][32];
    logic             q_sq  [NC][32];
    logic [4:0]       rd_ptr [NC];
    logic [4:0]       tail   [NC];
    logic [NC-1:0]    pend;
    int lim [NC] = '{2, 1, 1, 2, IW};

    for (genvar c = 0; c < NC; c++) begin : g_q
        assign head_valid[c]            = rd_ptr[c] != tail[c];
        assign head_seq[c*SEQ_W +: SEQ_W] = q_seq[c][rd_ptr[c]];
        assign head_squash[c]           = q_sq[c][rd_ptr[c]];
    end

    always @(negedge clk) pend <= pop;
    always @(posedge clk) begin
        for (int c = 0; c < NC; c++)
            if (!rst_n) rd_ptr[c] <= '0;
            else if (pend[c]) rd_ptr[c] <= rd_ptr[c] + 5'd1;
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct { logic [SEQ_W-1:0] seq; logic [2:0] cls; } item_t;
    item_t exp_q[$];
    int    exp_count;
    logic [4:0] exp_ptr [NC];
    string cur_tag = "R1";
    int    bundles = 0;
    int    freed   = 0;

    always @(negedge clk) begin
        if (rst_n && free_inc) freed++;
        if (rst_n && bundle_valid) begin
            bundles++;
            check(int'(issue_count) == exp_count, cur_tag, "issue_count",
                  int'(issue_count), exp_count);
            for (int s = 0; s < IW; s++) begin
                if (s < exp_count) begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(slot_valid[s] && slot_seq[s*SEQ_W +: SEQ_W] == it.seq,
                          cur_tag, $sformatf("slot%0d seq", s),
                          int'(slot_seq[s*SEQ_W +: SEQ_W]), int'(it.seq));
                    check(slot_cls[s*3 +: 3] == it.cls, cur_tag,
                          $sformatf("slot%0d class", s),
                          int'(slot_cls[s*3 +: 3]), int'(it.cls));
                end else begin
                    check(!slot_valid[s], cur_tag, $sformatf("slot%0d unused", s),
                          int'(slot_valid[s]), 0);
                end
            end
        end
    end

    task automatic put(input int c, input int seq, input bit sq);
        q_seq[c][tail[c]] = SEQ_W'(seq);
        q_sq[c][tail[c]]  = sq;
        tail[c]           = tail[c] + 5'd1;
    endtask

    // Reference from the requirements: oldest first, lowest class on tie,
    // lowest-class squashed eligible head dropped first, per-class caps.
    task automatic model_issue();
        logic [4:0] p [NC];
        int used [NC];
        int tot = 0;
        for (int c = 0; c < NC; c++) begin p[c] = rd_ptr[c]; used[c] = 0; end
        while (tot < IW) begin
            int best = -1;
            int sqc  = -1;
            for (int c = 0; c < NC; c++) begin
                if (p[c] != tail[c] && used[c] < lim[c]) begin
                    if (q_sq[c][p[c]] && sqc < 0) sqc = c;
                    if (best < 0 || q_seq[c][p[c]] < q_seq[best][p[best]]) best = c;
                end
            end
            if (best < 0) break;
            if (sqc >= 0) begin
                p[sqc] = p[sqc] + 5'd1;
                continue;
            end
            exp_q.push_back('{q_seq[best][p[best]], 3'(best)});
            used[best]++;
            p[best] = p[best] + 5'd1;
            tot++;
        end
        exp_count = tot;
        for (int c = 0; c < NC; c++) exp_ptr[c] = p[c];
    endtask

    task automatic run_case(input string tag, input bit restart_pulse);
        int b0;
        int f0;
        cur_tag = tag;
        model_issue();
        b0 = bundles;
        f0 = freed;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart_pulse) begin
            @(negedge clk); start = 1'b1;  // arrives during ST_PICK (R8)
            @(negedge clk); start = 1'b0;
        end
        while (bundles == b0) @(posedge clk);
        repeat (4) @(negedge clk);
        check(bundles == b0 + 1, tag, "bundles per start (R8)", bundles - b0, 1);
        check(freed - f0 == exp_count, tag, "free_inc pulses (R7)", freed - f0, exp_count);
        for (int c = 0; c < NC; c++)
            check(rd_ptr[c] == exp_ptr[c], tag, $sformatf("pops class%0d", c),
                  int'(rd_ptr[c]), int'(exp_ptr[c]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            tail[c] = '0;
            for (int i = 0; i < 32; i++) begin q_seq[c][i] = '0; q_sq[c][i] = 1'b0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy, "R1", "busy", int'(busy), 0);
        check(!bundle_valid, "R1", "bundle_valid", int'(bundle_valid), 0);
        check(pop == '0, "R1", "pop", int'(pop), 0);
        check(!free_inc, "R1", "free_inc", int'(free_inc), 0);
        check(slot_valid == '0, "R1", "slot_valid", int'(slot_valid), 0);

        // R3/R5 mixed classes: expect 1 mem, 3 fp, 4 misc, 5 int
        put(3, 1, 0); put(1, 3, 0); put(4, 4, 0); put(0, 5, 0); put(0, 9, 0); put(2, 7, 0);
        run_case("R5", 0);
        // R2 per-class caps with int/fp/br pressure
        put(0, 10, 0); put(0, 11, 0); put(0, 12, 0); put(2, 8, 0); put(1, 20, 0); put(1, 21, 0);
        run_case("R2", 0);
        // R3 tie: int 11 and misc 11 -> integer first
        put(4, 11, 0);
        run_case("R3", 0);
        // R4 squashed integer head dropped without a slot
        put(0, 30, 1); put(0, 31, 0); put(4, 22, 0);
        run_case("R4", 0);
        // R4 squashed head behind a class at its cap is left in place
        put(0, 40, 0); put(0, 41, 0); put(0, 42, 1);
        run_case("R4", 0);
        // R9 quota cleared: the capped class issues again next cycle
        put(0, 43, 0);
        run_case("R9", 0);
        // R6 misc bounded only by total width; R8 start pulse while busy
        for (int i = 0; i < 6; i++) put(4, 50 + i, 0);
        run_case("R8", 1);
        run_case("R6", 0);
        // R6 empty bundle
        run_case("R6", 0);
        // R4 only a squashed head: popped, zero issued
        put(1, 60, 1);
        run_case("R4", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule